// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two unsigned or two's-complement words of a parameterised width together with a single carry-in bit. It returns the word-wide sum and the carry out of the top bit. It is purely combinational and has no clock, so its outputs settle within the same cycle as its inputs. It suits datapaths where the carry chain is the critical path and a logarithmic carry depth is worth the extra prefix cells.

Internally, each bit position reduces its operand pair to a generate bit and a propagate bit. The incoming carry is placed as an extra position below bit 0. Its generate is the carry-in and its propagate is held at zero. A tree of merge cells then doubles the covered span at every level. After log2(WIDTH) levels, every bit position holds the carry arriving from all lower positions. Each sum bit is formed by XOR-ing the bit's half-sum with that carry. One further merge of the top bit with the carry beneath it gives the carry out.

Top module: `ppa_adder`

## Requirements
- R1: Each bit position i forms generate = a[i] AND b[i] and propagate = a[i] OR b[i], so a position with both operand bits 0 stops any carry and a position with both bits 1 produces one.
- R2: The carry-in acts as a position below bit 0 with generate = cin and propagate = 0; with cin = 1 the result is one greater than with cin = 0 for the same operands.
- R3: A merged span's generate is the upper part's generate OR (upper propagate AND lower generate), and its propagate is the AND of both propagates; alternating kill/generate/propagate patterns give the arithmetic sum.
- R4: The carry into bit i equals the carry out of the addition of bits i-1..0 with cin, for every i, including a carry that travels through all WIDTH positions (all-ones plus cin = 1 gives sum 0).
- R5: The output sum equals (a + b + cin) modulo 2^WIDTH for all operand values.
- R6: The carry output equals bit WIDTH of the exact sum a + b + cin.
- R7: WIDTH is a parameter with default 32, and it must be a power of two of at least 2. Any other value stops elaboration with an error.
- R8: The outputs depend only on the present inputs. No clock edge is needed between a change of a, b or cin and the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of bit WIDTH-1 |

## Verification
A 4-bit instance is driven with every combination of a, b and cin. This covers every kill, generate and propagate mix a short tree can see, and it separates a wrong merge rule from a wrong pass-through cell. The 32-bit instance first runs a table of hand-computed vectors. The table includes all-ones plus a carry-in, all-ones plus one, alternating 1010/0101 words with and without cin, and a sign-bit pair. These cases separate a carry that must cross every level from one that stays local. Random 32-bit operand pairs are then compared with a behavioural addition, which catches wiring slips at distances the table does not reach.

// File: rtl/ppa_pkg.sv
// Package: shared helpers for the parallel prefix adder.
// Holds the span merge rule so each level applies the same equation.
package ppa_pkg;

    // Merge an upper span with the span directly below it; returns {g, p}.
    function automatic logic [1:0] span_merge(
        input logic g_hi,
        input logic p_hi,
        input logic g_lo,
        input logic p_lo
    );
        logic g_out;
        logic p_out;
        g_out = g_hi | (p_hi & g_lo);
        p_out = p_hi & p_lo;
        return {g_out, p_out};
    endfunction

endpackage

// File: rtl/ppa_pg_column.sv
// Module: ppa_pg_column
// Forms per-position generate, propagate and half-sum bits.
// Assumes: index 0 of g/p is the carry-in position (below bit 0);
// index i+1 holds operand bit i.
module ppa_pg_column #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH:0]   g,
    output logic [WIDTH:0]   p,
    output logic [WIDTH-1:0] h
);

    // Carry-in position: generates cin, never propagates.
    always_comb begin
        g[0] = cin;
        p[0] = 1'b0;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Operand position: generate, propagate and half-sum for bit i.
        always_comb begin
            g[i+1] = a[i] & b[i];
            p[i+1] = a[i] | b[i];
            h[i]   = a[i] ^ b[i];
        end

        // A generating bit position always propagates as well.
        always_comb begin
            assert_gen_implies_prop_R1: assert (!g[i+1] || p[i+1])
                else $error("R1: bit %0d generates without propagating", i);
        end
    end

endmodule

// File: rtl/ppa_prefix_level.sv
// Module: ppa_prefix_level
// One level of the prefix tree: each entry at or above DIST merges with
// the entry DIST below it; lower entries are passed through unchanged.
// Assumes: entry 0 is the carry-in position with propagate 0, and every
// entry below 2*DIST on output covers a span reaching entry 0.
module ppa_prefix_level #(
    parameter int COLS = 33,
    parameter int DIST = 1
) (
    input  logic [COLS-1:0] g_in,
    input  logic [COLS-1:0] p_in,
    output logic [COLS-1:0] g_out,
    output logic [COLS-1:0] p_out
);
    import ppa_pkg::*;

    localparam int REACH = (2 * DIST < COLS) ? 2 * DIST : COLS;

    for (genvar k = 0; k < COLS; k++) begin : g_cell
        if (k >= DIST) begin : g_merge
            // Merge cell: combine span at k with the span ending at k-DIST.
            always_comb begin
                {g_out[k], p_out[k]} = span_merge(g_in[k], p_in[k],
                                                  g_in[k-DIST], p_in[k-DIST]);
            end
        end else begin : g_pass
            // Pass cell: span already reaches the carry-in position.
            always_comb begin
                g_out[k] = g_in[k];
                p_out[k] = p_in[k];
            end
        end
    end

    // Spans that reach the carry-in position can never propagate.
    always_comb begin
        for (int k = 0; k < REACH; k++) begin
            assert_floor_no_prop_R2: assert (p_out[k] == 1'b0)
                else $error("R2: entry %0d reaches carry-in yet propagates", k);
        end
    end

endmodule

// File: rtl/ppa_sum_stage.sv
// Module: ppa_sum_stage
// Forms the sum bits from half-sums and carries, and the carry out from
// the top span merged with the carry-in position.
// Assumes: carry[i] is the carry into bit i; g_top/p_top span bits
// WIDTH-1..0 (not the carry-in position).
module ppa_sum_stage #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] h,
    input  logic [WIDTH-1:0] carry,
    input  logic             g_top,
    input  logic             p_top,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    // Sum bits: half-sum XOR incoming carry.
    always_comb begin
        sum = h ^ carry;
    end

    // Carry out: top span generates, or propagates the carry-in.
    always_comb begin
        cout = g_top | (p_top & cin);
    end

endmodule

// File: rtl/ppa_adder.sv
// Module: ppa_adder (top)
// Combinational WIDTH-bit adder with carry-in, using a log-depth prefix
// tree of generate/propagate merges; the carry-in sits one position
// below bit 0.
// Assumes: WIDTH is a power of two, at least 2.
module ppa_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int LEVELS = $clog2(WIDTH);
    localparam int COLS   = WIDTH + 1;

    // Width guard: only powers of two are accepted.
    if (WIDTH < 2 || (1 << LEVELS) != WIDTH) begin : g_bad_width
        $error("ppa_adder: WIDTH must be a power of two >= 2");
    end

    logic [COLS-1:0]  g_lvl [LEVELS+1];
    logic [COLS-1:0]  p_lvl [LEVELS+1];
    logic [WIDTH-1:0] half;
    logic [WIDTH-1:0] carry;

    ppa_pg_column #(.WIDTH(WIDTH)) u_pg (
        .a   (a),
        .b   (b),
        .cin (cin),
        .g   (g_lvl[0]),
        .p   (p_lvl[0]),
        .h   (half)
    );

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        ppa_prefix_level #(.COLS(COLS), .DIST(1 << l)) u_level (
            .g_in  (g_lvl[l]),
            .p_in  (p_lvl[l]),
            .g_out (g_lvl[l+1]),
            .p_out (p_lvl[l+1])
        );
    end

    // Carry into bit i is the final generate of entry i (span i-1..-1).
    always_comb begin
        carry = g_lvl[LEVELS][WIDTH-1:0];
    end

    ppa_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .h     (half),
        .carry (carry),
        .g_top (g_lvl[LEVELS][WIDTH]),
        .p_top (p_lvl[LEVELS][WIDTH]),
        .cin   (cin),
        .sum   (sum),
        .cout  (cout)
    );

    // Carries obey the bitwise ripple recurrence from the operand bits.
    always_comb begin
        assert_carry_base_R2: assert (carry[0] == cin)
            else $error("R2: carry into bit 0 differs from cin");
        for (int i = 1; i < WIDTH; i++) begin
            assert_carry_chain_R4: assert (carry[i] ==
                ((a[i-1] & b[i-1]) | ((a[i-1] | b[i-1]) & carry[i-1])))
                else $error("R4: carry into bit %0d inconsistent", i);
        end
    end

    // Result matches the behavioural sum at the ports.
    always_comb begin
        assert_sum_value_R5: assert (sum == WIDTH'(a + b + WIDTH'(cin)))
            else $error("R5: sum mismatch");
        assert_carry_out_R6: assert (cout ==
            (((a[WIDTH-1] & b[WIDTH-1]) | ((a[WIDTH-1] | b[WIDTH-1]) & carry[WIDTH-1]))))
            else $error("R6: carry out mismatch");
    end

endmodule

// File: tb/ppa_adder_bench.sv
// Bench for ppa_adder: table walk and random vectors at WIDTH 32,
// exhaustive sweep at WIDTH 4, plus directed reset and corner cases.
module ppa_adder_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] a32, b32, s32;
    logic        c32, co32;
    logic [3:0]  a4, b4, s4;
    logic        c4, co4;

    ppa_adder #(.WIDTH(32)) u_ppa_adder (
        .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(co32));

    ppa_adder #(.WIDTH(4)) u_ppa_adder_w4 (
        .a(a4), .b(b4), .cin(c4), .sum(s4), .cout(co4));

    // Vector layout: {a, b, cin, expected cout, expected sum}.
    localparam int NVEC = 10;
    localparam logic [97:0] VEC [NVEC] = '{
        {32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'hFFFF_FFFF},
        {32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1, 32'h0000_0000},
        {32'h1234_5678, 32'h1111_1111, 1'b0, 1'b0, 32'h2345_6789},
        {32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 1'b0, 32'hFFFF_FFFF},
        {32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 1'b1, 32'h0000_0000},
        {32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 32'h8000_0000},
        {32'h0000_0005, 32'h0000_0003, 1'b1, 1'b0, 32'h0000_0009}
    };

    task automatic check(input bit ok, input string req,
                         input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [32:0] exp33;
        logic [4:0]  exp5;
        a32 = '0; b32 = '0; c32 = 1'b0;
        a4 = '0; b4 = '0; c4 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: zero inputs give zero outputs (R5, R6).
        check({co32, s32} == 33'd0, "R5 reset zero", {co32, s32}, 33'd0);
        check({co4, s4} == 5'd0, "R6 reset zero w4", {28'd0, co4, s4}, 33'd0);
        rst_n = 1'b1;

        // Table walk (R1 R2 R3 R4 R5 R6).
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            {a32, b32, c32} = VEC[v][97:33];
            #1;
            check({co32, s32} == VEC[v][32:0], "R3 R5 table vector",
                  {co32, s32}, VEC[v][32:0]);
        end

        // Exhaustive WIDTH 4 sweep (R1 R3 R5 R6 R7).
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int z = 0; z < 2; z++) begin
                    @(negedge clk);
                    a4 = 4'(x); b4 = 4'(y); c4 = 1'(z);
                    #1;
                    exp5 = 5'(x + y + z);
                    check({co4, s4} == exp5, "R5 R6 exhaustive w4",
                          {28'd0, co4, s4}, {28'd0, exp5});
                end
            end
        end

        // Random 32-bit vectors against behavioural addition (R5 R6).
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
            #1;
            exp33 = {1'b0, a32} + {1'b0, b32} + {32'd0, c32};
            check({co32, s32} == exp33, "R5 R6 random", {co32, s32}, exp33);
        end

        // R2: cin adds exactly one for fixed operands.
        @(negedge clk);
        a32 = 32'h0F0F_F0F0; b32 = 32'h00F0_0F0F; c32 = 1'b0;
        #1;
        exp33 = {co32, s32} + 33'd1;
        c32 = 1'b1;
        #1;
        check({co32, s32} == exp33, "R2 carry-in adds one", {co32, s32}, exp33);

        // R4: carry crossing all positions, all-ones plus cin.
        a32 = 32'hFFFF_FFFF; b32 = 32'h0; c32 = 1'b1;
        #1;
        check({co32, s32} == {1'b1, 32'h0}, "R4 full-length carry",
              {co32, s32}, {1'b1, 32'h0});

        // R8: output follows inputs without a clock edge (mid-cycle change).
        a32 = 32'h0000_00FF; b32 = 32'h0000_0001; c32 = 1'b0;
        #1;
        check({co32, s32} == 33'h100, "R8 no clock needed", {co32, s32}, 33'h100);

        // R1: kill positions stop carries; generate positions start them.
        a32 = 32'h0000_0F00; b32 = 32'h0000_0100; c32 = 1'b1;
        #1;
        check({co32, s32} == 33'h0000_1001, "R1 kill and generate",
              {co32, s32}, 33'h0000_1001);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule